// File: doc/BRIEF.md
# Two-Rate Row Refresh Scheduler

This block decides, row by row, whether a DRAM row gets a refresh command. A small table holds one bit per row. A 1 marks a row that holds at least one weak cell, and that row is refreshed on every normal pass. A 0 marks a row with only strong cells, and that row only needs the slow period, which is a whole multiple of the normal one. The block steps through the rows in a fixed round-robin order and evaluates one row every `SLOT_CYC` clocks, so a full pass over all rows takes one normal refresh period. A phase counter runs from 0 to `SLOW_RATIO`-1 and advances once per pass. A row marked 0 receives a refresh only in the pass where the phase is 0. In every other pass its turn is skipped, and the skip is counted.

The table starts with every row at the normal rate. A retest strobe reloads the whole table from the profiling vector. At any time, the upgrade port can promote a single row to the normal rate. This is how an error-correction report on that row is handled. The promotion lasts until the next retest. Periods and the row count are parameters, so a simulation covers many passes in a few hundred clocks.

Top module: `mrr_refresh_sched`

## Requirements
- R1: While reset is high, `ref_req` is 0 and both counters are 0. After reset every table bit is 1 (normal), so with no retest every evaluation issues a refresh.
- R2: A row is evaluated every `SLOT_CYC` clocks. Rows are evaluated in ascending order from 0 and wrap after `ROWS`-1. The phase advances by one, modulo `SLOW_RATIO`, after row `ROWS`-1 has been evaluated.
- R3: An evaluated row whose table bit is 1 produces a refresh strobe carrying that row's address.
- R4: An evaluated row whose table bit is 0 produces a strobe only when the phase is 0. Otherwise no strobe is produced and `ref_skipped` increments.
- R5: Each evaluation increments exactly one of `ref_issued` or `ref_skipped` by one.
- R6: A clock with `retest` high loads the table from `prof_map`, where bit i = 1 marks row i as normal rate.
- R7: A clock with `upg_valid` high sets the bit of row `upg_row` to 1. The bit stays 1 until a later retest loads it again.
- R8: An upgrade in the same clock as the evaluation of the same row is applied to that evaluation, and the row is refreshed.
- R9: When `retest` and `upg_valid` are high in the same clock, the upgraded row ends at 1 and every other row takes its value from `prof_map`.
- R10: `ref_req` lasts one clock per issued refresh. Its results appear one clock after the evaluation edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_map | input | ROWS | Profiling result, bit i = 1 marks row i as normal rate |
| retest | input | 1 | Reload the table from `prof_map` |
| upg_valid | input | 1 | Promote row `upg_row` to normal rate |
| upg_row | input | ROW_W | Row to promote |
| ref_req | output | 1 | One-clock refresh strobe |
| ref_row | output | ROW_W | Row address qualified by `ref_req` |
| ref_issued | output | CNT_W | Count of refreshes issued |
| ref_skipped | output | CNT_W | Count of slow-row refreshes skipped |

## Verification
Two functions can land in the same clock. The first case is a row promotion arriving on exactly the clock that evaluates that row. The second is a promotion arriving together with a retest. The bench provokes the first by raising `upg_valid` for a slow row on the clock of that row's evaluation in a non-zero phase. It passes if a strobe for that row appears on the next clock and the issue and skip totals over the following passes match a table with that bit set. The bench provokes the second by raising both inputs on the first clock after reset and checking that the totals for a whole slow period count the promoted row as normal.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  // Outcome of one row evaluation.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ISSUE = 2'd1,
    ACT_SKIP  = 2'd2
  } act_e;

  // Safe index width for a count of items.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mrr_rate_table.sv
module mrr_rate_table #(
  parameter int ROWS  = 8,
  parameter int ROW_W = mrr_pkg::idx_w(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROWS-1:0]  prof_map,
  input  logic             retest,
  input  logic             upg_valid,
  input  logic [ROW_W-1:0] upg_row,
  input  logic [ROW_W-1:0] rd_row,
  output logic             rd_normal
);

  logic [ROWS-1:0] tbl_q;
  logic [ROWS-1:0] upg_mask;

  // Decode the upgrade request into a one-hot row mask.
  for (genvar g = 0; g < ROWS; g++) begin : g_mask
    assign upg_mask[g] = upg_valid && (upg_row == ROW_W'(g));
  end

  // Table write: a retest reloads every row, and an upgrade in the same clock still wins for its row.
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '1;
    end else if (retest) begin
      tbl_q <= prof_map | upg_mask;
    end else begin
      tbl_q <= tbl_q | upg_mask;
    end
  end

  // Read with bypass, so an upgrade in the evaluation clock counts.
  logic rd_hit;
  always_comb begin
    rd_hit    = upg_valid && (upg_row == rd_row);
    rd_normal = rd_hit;
    if (int'(rd_row) < ROWS) rd_normal = tbl_q[rd_row] | rd_hit;
  end

  // R7 / R9: a promoted row reads as normal on the following clock.
  a_r7_upgrade_sticks: assert property (@(posedge clk) disable iff (rst)
    (upg_valid && (int'(upg_row) < ROWS)) |=> tbl_q[$past(upg_row)]);

  // R6: without an upgrade, a retest copies the profiling vector.
  a_r6_retest_loads: assert property (@(posedge clk) disable iff (rst)
    (retest && !upg_valid) |=> (tbl_q == $past(prof_map)));

endmodule

// File: rtl/mrr_walker.sv
module mrr_walker #(
  parameter int ROWS       = 8,
  parameter int SLOT_CYC   = 4,
  parameter int SLOW_RATIO = 4,
  parameter int ROW_W      = mrr_pkg::idx_w(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             eval,
  output logic [ROW_W-1:0] row,
  output logic             phase_zero
);

  localparam int SL_W = mrr_pkg::idx_w(SLOT_CYC);
  localparam int PH_W = mrr_pkg::idx_w(SLOW_RATIO);
  localparam logic [SL_W-1:0]  SLOT_LAST  = SL_W'(SLOT_CYC - 1);
  localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(ROWS - 1);
  localparam logic [PH_W-1:0]  PHASE_LAST = PH_W'(SLOW_RATIO - 1);

  logic [SL_W-1:0]  slot_q;
  logic [ROW_W-1:0] ptr_q;
  logic [PH_W-1:0]  phase_q;

  assign eval       = (slot_q == SLOT_LAST);
  assign row        = ptr_q;
  assign phase_zero = (phase_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      ptr_q   <= '0;
      phase_q <= '0;
    end else if (eval) begin
      slot_q <= '0;
      if (ptr_q == ROW_LAST) begin
        ptr_q   <= '0;
        phase_q <= (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  // R2: evaluations are spaced and never back to back.
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    eval |=> !eval);

  // R2: the row pointer holds between evaluations.
  a_r2_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(ptr_q) && $stable(phase_q));

  // R2: the phase moves only when the last row wraps.
  a_r2_phase_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (eval && (ptr_q != ROW_LAST)) |=> $stable(phase_q));

endmodule

// File: rtl/mrr_decide.sv
module mrr_decide #(
  parameter int ROW_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval,
  input  logic [ROW_W-1:0] row,
  input  logic             row_normal,
  input  logic             phase_zero,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic [CNT_W-1:0] cnt_iss,
  output logic [CNT_W-1:0] cnt_skp
);
  import mrr_pkg::*;

  act_e act;

  always_comb begin
    if (!eval)                         act = ACT_NONE;
    else if (row_normal || phase_zero) act = ACT_ISSUE;
    else                               act = ACT_SKIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_req <= 1'b0;
      ref_row <= '0;
      cnt_iss <= '0;
      cnt_skp <= '0;
    end else begin
      ref_req <= (act == ACT_ISSUE);
      if (act == ACT_ISSUE) begin
        ref_row <= row;
        cnt_iss <= cnt_iss + 1'b1;
      end
      if (act == ACT_SKIP) cnt_skp <= cnt_skp + 1'b1;
    end
  end

  // R3: a normal-rate row is always refreshed, with its own address.
  a_r3_normal_refreshed: assert property (@(posedge clk) disable iff (rst)
    (eval && row_normal) |=> (ref_req && (ref_row == $past(row))));

  // R4: a slow row outside phase 0 is skipped and counted.
  a_r4_slow_skipped: assert property (@(posedge clk) disable iff (rst)
    (eval && !row_normal && !phase_zero) |=> (!ref_req && (cnt_skp == $past(cnt_skp) + 1'b1)));

  // R5: each evaluation adds one to the combined total.
  a_r5_one_count: assert property (@(posedge clk) disable iff (rst)
    eval |=> ((CNT_W+1)'(cnt_iss) + (CNT_W+1)'(cnt_skp) ==
              (CNT_W+1)'($past(cnt_iss)) + (CNT_W+1)'($past(cnt_skp)) + 1'b1));

  // R10: the strobe lasts one clock.
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    ref_req |=> !ref_req);

endmodule

// File: rtl/mrr_refresh_sched.sv
module mrr_refresh_sched #(
  parameter int ROWS       = 8,
  parameter int SLOT_CYC   = 4,
  parameter int SLOW_RATIO = 4,
  parameter int CNT_W      = 16,
  parameter int ROW_W      = mrr_pkg::idx_w(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROWS-1:0]  prof_map,
  input  logic             retest,
  input  logic             upg_valid,
  input  logic [ROW_W-1:0] upg_row,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic [CNT_W-1:0] ref_issued,
  output logic [CNT_W-1:0] ref_skipped
);

  logic             eval;
  logic [ROW_W-1:0] cur_row;
  logic             phase_zero;
  logic             row_normal;

  mrr_walker #(
    .ROWS(ROWS), .SLOT_CYC(SLOT_CYC), .SLOW_RATIO(SLOW_RATIO), .ROW_W(ROW_W)
  ) u_walker (
    .clk(clk), .rst(rst), .eval(eval), .row(cur_row), .phase_zero(phase_zero)
  );

  mrr_rate_table #(
    .ROWS(ROWS), .ROW_W(ROW_W)
  ) u_table (
    .clk(clk), .rst(rst), .prof_map(prof_map), .retest(retest),
    .upg_valid(upg_valid), .upg_row(upg_row),
    .rd_row(cur_row), .rd_normal(row_normal)
  );

  mrr_decide #(
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_decide (
    .clk(clk), .rst(rst), .eval(eval), .row(cur_row),
    .row_normal(row_normal), .phase_zero(phase_zero),
    .ref_req(ref_req), .ref_row(ref_row),
    .cnt_iss(ref_issued), .cnt_skp(ref_skipped)
  );

  // R1: no strobe on the clock after a reset clock.
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!ref_req && (ref_issued == '0) && (ref_skipped == '0)));

  // R8: an upgrade on the evaluated row forces a refresh of that row.
  a_r8_same_cycle_upgrade: assert property (@(posedge clk) disable iff (rst)
    (eval && upg_valid && (upg_row == cur_row)) |=> (ref_req && (ref_row == $past(cur_row))));

endmodule

// File: tb/mrr_refresh_sched_bench.sv
module mrr_refresh_sched_bench;

  localparam int ROWS = 8;
  localparam int RW   = 3;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [ROWS-1:0] prof_map = '0;
  logic          retest = 1'b0;
  logic          upg_valid = 1'b0;
  logic [RW-1:0] upg_row = '0;
  logic          ref_req;
  logic [RW-1:0] ref_row;
  logic [CW-1:0] ref_issued;
  logic [CW-1:0] ref_skipped;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  mrr_refresh_sched #(.ROWS(ROWS), .SLOT_CYC(4), .SLOW_RATIO(4), .CNT_W(CW)) u_mrr_refresh_sched (
    .clk(clk), .rst(rst), .prof_map(prof_map), .retest(retest),
    .upg_valid(upg_valid), .upg_row(upg_row),
    .ref_req(ref_req), .ref_row(ref_row),
    .ref_issued(ref_issued), .ref_skipped(ref_skipped)
  );

  // {map, issued over 4 passes, skipped over 4 passes}: issued = 3n+8, skipped = 3(8-n).
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'd8,  8'd24},
    {8'hFF, 8'd32, 8'd0 },
    {8'h01, 8'd11, 8'd21},
    {8'hA5, 8'd20, 8'd12},
    {8'h7E, 8'd26, 8'd6 },
    {8'h10, 8'd11, 8'd21}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Reset, then on the first clock optionally retest and/or upgrade. Returns after clock 1.
  task automatic start(input logic do_rt, input logic [ROWS-1:0] map,
                       input logic do_up, input logic [RW-1:0] urow);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst       = 1'b0;
    retest    = do_rt;
    prof_map  = map;
    upg_valid = do_up;
    upg_row   = urow;
    cyc       = 0;
    adv(1);
    retest    = 1'b0;
    upg_valid = 1'b0;
  endtask

  initial begin
    // Vector table: totals over one full slow period (R3, R4, R5, R6).
    for (int v = 0; v < 6; v++) begin
      start(1'b1, VEC[v][23:16], 1'b0, '0);
      adv(129);
      chk("R4/R6 issued", int'(ref_issued), int'(VEC[v][15:8]));
      chk("R4/R5 skipped", int'(ref_skipped), int'(VEC[v][7:0]));
    end

    // R1: reset clears outputs even after activity.
    @(negedge clk);
    rst = 1'b1;
    adv(2);
    chk("R1 ref_req in reset", int'(ref_req), 0);
    chk("R1 issued in reset", int'(ref_issued), 0);
    chk("R1 skipped in reset", int'(ref_skipped), 0);

    // R1: table is all normal after reset with no retest.
    start(1'b0, 8'h00, 1'b0, '0);
    adv(129);
    chk("R1 default normal issued", int'(ref_issued), 32);
    chk("R1 default normal skipped", int'(ref_skipped), 0);

    // R2 / R10: strobe timing and row order with all rows normal.
    start(1'b1, 8'hFF, 1'b0, '0);
    while (cyc < 37) begin
      adv(1);
      if (cyc % 4 == 0) begin
        chk("R10 strobe on evaluation", int'(ref_req), 1);
        chk("R2 row order", int'(ref_row), (cyc / 4 - 1) % ROWS);
      end else begin
        chk("R10 strobe width", int'(ref_req), 0);
      end
    end

    // R4: slow row 0 refreshed in phase 0 (clock 4), skipped in phase 1 (clock 36).
    start(1'b1, 8'hFE, 1'b0, '0);
    adv(3);
    chk("R4 slow row phase 0", int'(ref_req), 1);
    chk("R4 slow row phase 0 addr", int'(ref_row), 0);
    adv(32);
    chk("R4 slow row phase 1 skipped", int'(ref_req), 0);

    // R8: upgrade row 3 on the clock it is evaluated in phase 1 (clock 48).
    start(1'b1, 8'h00, 1'b0, '0);
    adv(46);
    upg_valid = 1'b1;
    upg_row   = 3'd3;
    adv(1);
    upg_valid = 1'b0;
    chk("R8 same-cycle upgrade strobe", int'(ref_req), 1);
    chk("R8 same-cycle upgrade addr", int'(ref_row), 3);
    adv(82);
    chk("R8 issued", int'(ref_issued), 11);
    chk("R8 skipped", int'(ref_skipped), 21);

    // R9: retest and upgrade of row 6 together.
    start(1'b1, 8'h00, 1'b1, 3'd6);
    adv(129);
    chk("R9 issued", int'(ref_issued), 11);
    chk("R9 skipped", int'(ref_skipped), 21);

    // R7: upgrade of row 5 persists, then a retest reverts it.
    start(1'b1, 8'h00, 1'b0, '0);
    upg_valid = 1'b1;
    upg_row   = 3'd5;
    adv(1);
    upg_valid = 1'b0;
    adv(127);
    chk("R7 issued after upgrade", int'(ref_issued), 11);
    chk("R7 skipped after upgrade", int'(ref_skipped), 21);
    retest   = 1'b1;
    prof_map = 8'h00;
    adv(1);
    retest = 1'b0;
    adv(127);
    chk("R7 issued after retest", int'(ref_issued), 19);
    chk("R7 skipped after retest", int'(ref_skipped), 45);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule